// File: doc/BRIEF.md
# Pipelined Signed Dadda Multiplier

This block multiplies two 16-bit two's-complement operands and returns the full 32-bit two's-complement product. It accepts a new operand pair on every clock edge and returns each product exactly six edges after the operands were sampled. There is no handshake. A result leaves the pipeline on every cycle, and the surrounding logic keeps its own count of the latency.

The operand bits are ANDed into a partial-product array. Sign handling is folded into that array instead of sign-extending the operands: every partial product that pairs exactly one operand's top bit with a lower bit of the other operand is inverted, and a constant one is added at weight 16 and at weight 31. A Dadda tree then reduces the column heights step by step, through the targets 13, 9, 6, 4, 3 and 2. Each step inserts only the half and full adders needed to reach the next target. The last two rows meet in a 30-bit Brent-Kung prefix adder that covers weights 1 to 30. Weight 0 needs no addition. Weight 31 takes the carry out of the prefix tree.

The six register banks split the work as follows:
- Stage 1: the AND array and tree level 1.
- Stage 2: tree levels 2 and 3.
- Stage 3: tree levels 4 and 5.
- Stage 4: tree level 6 and the generate/propagate formation.
- Stage 5: the up-sweep of the prefix tree.
- Stage 6: the down-sweep and the final sum.

Top module: `dadda_mul_pipe`

## Requirements
- R1: `q` equals the signed product of the `x_in`/`y_in` pair sampled six rising edges earlier. A different pair may be applied on every edge.
- R2: With `rst` high at a rising edge (synchronous, active high), every pipeline register clears. `q` reads zero after that edge and stays zero for the first five edges after `rst` goes low, whatever the operands are.
- R3: Products with negative operands, in either or both positions, appear as 32-bit two's complement values.
- R4: Operands equal to -32768 (0x8000) give exact results. -32768 × -32768 yields 0x40000000, and -32768 × -1 yields 0x00008000.
- R5: The bits held after stage 1, stage 2 and stage 3, when weighted by their column (column c has weight 2^c), sum modulo 2^32 to the product of the operands sampled 1, 2 and 3 edges earlier.
- R6: After stage 4, the value lsb + 2·propagate + 4·generate + 2^31·top-half (modulo 2^32) equals the product of the operands sampled four edges earlier. The prefix adder resolves carries that ripple across all 30 adder positions, as for 32767 × 32767 = 0x3FFF0001 and -1 × 1 = 0xFFFFFFFF.
- R7: Consecutive products in an unbroken stream do not disturb one another. Every result matches its own pair, and no result is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all pipeline registers |
| rst | input | 1 | Synchronous active-high reset, clears every pipeline register |
| x_in | input | 16 | Multiplicand, two's complement |
| y_in | input | 16 | Multiplier, two's complement |
| q | output | 32 | Product, two's complement, six edges after its operands |

## Verification
The assertions assume that `x_in` and `y_in` carry known values on every rising edge once reset is released. They also assume that the value-tracking properties start only after enough non-reset edges have passed to fill the stage they examine. A saturating fill counter provides that guard. The stimulus therefore drives a defined pair on every cycle after reset, including idle zero pairs at the tail. It never leaves an operand undriven, and it restarts the fill by asserting reset in the middle of a stream. Random pairs cover the full signed range, and directed pairs hit the most-negative operand and the long carry chains.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;
    localparam int MAXH   = OP_W;
    localparam int CPA_W  = PROD_W - 2;
    localparam int BK_LV  = $clog2(CPA_W);
    localparam int BK_W   = 1 << BK_LV;

    typedef logic [MAXH-1:0] col_t;
    typedef col_t [PROD_W-1:0] mat_t;
    typedef int hvec_t [PROD_W];

    typedef struct packed {
        logic [CPA_W-1:0] gen;
        logic [CPA_W-1:0] prop;
        logic             lsb;
        logic             msb_half;
    } gp_t;

    typedef struct packed {
        logic [BK_W-1:0]  grp_g;
        logic [BK_W-1:0]  grp_p;
        logic [CPA_W-1:0] prop;
        logic             lsb;
        logic             msb_half;
    } tree_t;

    // Number of height-reduction levels needed for the tallest column.
    function automatic int dadda_levels();
        int d;
        int n;
        d = 2;
        n = 0;
        while (d < MAXH) begin
            n++;
            d = (d * 3) / 2;
        end
        return n;
    endfunction

    localparam int NLEV = dadda_levels();

    // Target height after level lvl (1 = first level applied).
    function automatic int level_target(input int lvl);
        int d;
        d = 2;
        for (int k = 0; k < NLEV - lvl; k++) d = (d * 3) / 2;
        return d;
    endfunction

    // Column heights of the sign-corrected partial-product array.
    function automatic void pp_heights(output hvec_t h);
        for (int c = 0; c < PROD_W; c++) h[c] = 0;
        for (int i = 0; i < OP_W; i++)
            for (int j = 0; j < OP_W; j++) h[i+j]++;
        h[OP_W]++;
        h[PROD_W-1]++;
    endfunction

    // Sign-corrected partial products, packed to the bottom of each column.
    function automatic mat_t build_pp(input logic [OP_W-1:0] xa, input logic [OP_W-1:0] ya);
        mat_t  m;
        hvec_t fillh;
        logic  b;
        m = '0;
        for (int c = 0; c < PROD_W; c++) fillh[c] = 0;
        for (int i = 0; i < OP_W; i++) begin
            for (int j = 0; j < OP_W; j++) begin
                b = xa[i] & ya[j];
                if ((i == OP_W-1) != (j == OP_W-1)) b = ~b;
                m[i+j][fillh[i+j]] = b;
                fillh[i+j]++;
            end
        end
        m[OP_W][fillh[OP_W]]         = 1'b1;
        m[PROD_W-1][fillh[PROD_W-1]] = 1'b1;
        return m;
    endfunction

    // One Dadda level: just enough adders to meet tgt in every column.
    function automatic void dadda_level(input mat_t m_in, input hvec_t h_in, input int tgt,
                                        output mat_t m_out, output hvec_t h_out);
        int   cc;
        int   ncc;
        int   pos;
        int   idx;
        int   excess;
        int   nfa;
        int   nha;
        col_t cbuf;
        col_t nbuf;
        logic a;
        logic b;
        logic ci;
        m_out = '0;
        cc    = 0;
        cbuf  = '0;
        for (int c = 0; c < PROD_W; c++) begin
            excess = h_in[c] + cc - tgt;
            nfa    = (excess > 0) ? excess / 2 : 0;
            nha    = (excess > 0) ? excess % 2 : 0;
            pos    = 0;
            idx    = 0;
            ncc    = 0;
            nbuf   = '0;
            for (int k = 0; k < MAXH; k++) begin
                if (k < cc) begin
                    m_out[c][pos] = cbuf[k];
                    pos++;
                end
            end
            for (int k = 0; k < MAXH; k++) begin
                if (k < nfa) begin
                    a  = m_in[c][idx];
                    b  = m_in[c][idx+1];
                    ci = m_in[c][idx+2];
                    idx += 3;
                    m_out[c][pos] = a ^ b ^ ci;
                    pos++;
                    nbuf[ncc] = (a & b) | (a & ci) | (b & ci);
                    ncc++;
                end
            end
            if (nha == 1) begin
                a = m_in[c][idx];
                b = m_in[c][idx+1];
                idx += 2;
                m_out[c][pos] = a ^ b;
                pos++;
                nbuf[ncc] = a & b;
                ncc++;
            end
            for (int k = 0; k < MAXH; k++) begin
                if (k >= idx && k < h_in[c]) begin
                    m_out[c][pos] = m_in[c][k];
                    pos++;
                end
            end
            h_out[c] = pos;
            cc       = ncc;
            cbuf     = nbuf;
        end
    endfunction

    // Two final rows into generate/propagate for weights 1..CPA_W.
    function automatic gp_t form_gp(input mat_t m);
        gp_t r;
        r.lsb      = m[0][0];
        r.msb_half = m[PROD_W-1][0] ^ m[PROD_W-1][1];
        for (int j = 0; j < CPA_W; j++) begin
            r.gen[j]  = m[j+1][0] & m[j+1][1];
            r.prop[j] = m[j+1][0] ^ m[j+1][1];
        end
        return r;
    endfunction

    // Checking helpers (used by assertions only).
    function automatic logic [PROD_W-1:0] mat_value(input mat_t m);
        logic [PROD_W-1:0] acc;
        acc = '0;
        for (int c = 0; c < PROD_W; c++)
            for (int k = 0; k < MAXH; k++)
                acc = acc + (PROD_W'(m[c][k]) << c);
        return acc;
    endfunction

    function automatic logic [PROD_W-1:0] gp_value(input gp_t g);
        return PROD_W'(g.lsb) + (PROD_W'(g.prop) << 1) + (PROD_W'(g.gen) << 2)
             + (PROD_W'(g.msb_half) << (PROD_W-1));
    endfunction

    function automatic logic [PROD_W-1:0] exact_product(input logic [OP_W-1:0] a,
                                                        input logic [OP_W-1:0] b);
        logic signed [PROD_W-1:0] sa;
        logic signed [PROD_W-1:0] sb;
        sa = signed'({{OP_W{a[OP_W-1]}}, a});
        sb = signed'({{OP_W{b[OP_W-1]}}, b});
        return sa * sb;
    endfunction

endpackage

// File: rtl/sdm_ppgen.sv
module sdm_ppgen
    import sdm_pkg::*;
(
    input  logic [OP_W-1:0] xa,
    input  logic [OP_W-1:0] ya,
    output mat_t            pp
);

    always_comb pp = build_pp(xa, ya);

endmodule

// File: rtl/sdm_dadda_slice.sv
module sdm_dadda_slice
    import sdm_pkg::*;
#(
    parameter int FIRST_LVL = 1,
    parameter int NUM_LVL   = 1
) (
    input  mat_t m_in,
    output mat_t m_out
);

    always_comb begin
        mat_t  zm;
        mat_t  work;
        mat_t  tmp_m;
        hvec_t h;
        hvec_t tmp_h;
        zm = '0;
        pp_heights(h);
        // Replay earlier levels on heights only, so this slice knows its input shape.
        for (int l = 1; l < FIRST_LVL; l++) begin
            dadda_level(zm, h, level_target(l), tmp_m, tmp_h);
            h = tmp_h;
        end
        work = m_in;
        for (int l = FIRST_LVL; l < FIRST_LVL + NUM_LVL; l++) begin
            dadda_level(work, h, level_target(l), tmp_m, tmp_h);
            work = tmp_m;
            h    = tmp_h;
        end
        m_out = work;
    end

endmodule

// File: rtl/sdm_bk_up.sv
module sdm_bk_up
    import sdm_pkg::*;
(
    input  gp_t   gp_in,
    output tree_t tr_out
);

    always_comb begin
        logic [BK_W-1:0] g;
        logic [BK_W-1:0] p;
        int              step;
        g = '0;
        p = '0;
        g[CPA_W-1:0] = gp_in.gen;
        p[CPA_W-1:0] = gp_in.prop;
        for (int d = 0; d < BK_LV; d++) begin
            step = 1 << d;
            for (int i = 0; i < BK_W; i++) begin
                if (((i + 1) % (2 * step)) == 0) begin
                    g[i] = g[i] | (p[i] & g[i-step]);
                    p[i] = p[i] & p[i-step];
                end
            end
        end
        tr_out.grp_g    = g;
        tr_out.grp_p    = p;
        tr_out.prop     = gp_in.prop;
        tr_out.lsb      = gp_in.lsb;
        tr_out.msb_half = gp_in.msb_half;
    end

endmodule

// File: rtl/sdm_bk_down.sv
module sdm_bk_down
    import sdm_pkg::*;
(
    input  tree_t             tr_in,
    output logic [PROD_W-1:0] sum
);

    always_comb begin
        logic [BK_W-1:0] g;
        logic [BK_W-1:0] p;
        int              step;
        logic            cin;
        g = tr_in.grp_g;
        p = tr_in.grp_p;
        for (int d = BK_LV - 2; d >= 0; d--) begin
            step = 1 << d;
            for (int i = 0; i < BK_W; i++) begin
                if (i >= 2 * step && ((i + 1) % (2 * step)) == step) begin
                    g[i] = g[i] | (p[i] & g[i-step]);
                    p[i] = p[i] & p[i-step];
                end
            end
        end
        sum[0] = tr_in.lsb;
        for (int j = 0; j < CPA_W; j++) begin
            cin      = (j == 0) ? 1'b0 : g[j-1];
            sum[j+1] = tr_in.prop[j] ^ cin;
        end
        sum[PROD_W-1] = tr_in.msb_half ^ g[CPA_W-1];
    end

endmodule

// File: rtl/dadda_mul_pipe.sv
module dadda_mul_pipe
    import sdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   x_in,
    input  logic [OP_W-1:0]   y_in,
    output logic [PROD_W-1:0] q
);

    mat_t              pp, s1_m, s2_m, s3_m, s4_m;
    mat_t              r1, r2, r3;
    gp_t               s4_gp, r4;
    tree_t             s5_tr, r5;
    logic [PROD_W-1:0] s6_sum;
    logic [2:0]        fill;

    // Stage 1: partial products and tree level 1
    sdm_ppgen u_pp (.xa(x_in), .ya(y_in), .pp(pp));
    sdm_dadda_slice #(.FIRST_LVL(1), .NUM_LVL(1)) u_lv1 (.m_in(pp), .m_out(s1_m));
    // Stage 2: levels 2-3
    sdm_dadda_slice #(.FIRST_LVL(2), .NUM_LVL(2)) u_lv23 (.m_in(r1), .m_out(s2_m));
    // Stage 3: levels 4-5
    sdm_dadda_slice #(.FIRST_LVL(4), .NUM_LVL(2)) u_lv45 (.m_in(r2), .m_out(s3_m));
    // Stage 4: level 6 and generate/propagate
    sdm_dadda_slice #(.FIRST_LVL(6), .NUM_LVL(NLEV - 5)) u_lv6 (.m_in(r3), .m_out(s4_m));
    always_comb s4_gp = form_gp(s4_m);
    // Stage 5: prefix up-sweep
    sdm_bk_up u_up (.gp_in(r4), .tr_out(s5_tr));
    // Stage 6: prefix down-sweep and sum
    sdm_bk_down u_dn (.tr_in(r5), .sum(s6_sum));

    always_ff @(posedge clk) begin
        if (rst) begin
            r1   <= '0;
            r2   <= '0;
            r3   <= '0;
            r4   <= '0;
            r5   <= '0;
            q    <= '0;
            fill <= '0;
        end else begin
            r1 <= s1_m;
            r2 <= s2_m;
            r3 <= s3_m;
            r4 <= s4_gp;
            r5 <= s5_tr;
            q  <= s6_sum;
            if (fill != 3'd7) fill <= fill + 3'd1;
        end
    end

    // R5: reduction registers keep the arithmetic value of the product
    a_r5_stage1_value: assert property (@(posedge clk) disable iff (rst)
        (fill >= 3'd1) |-> mat_value(r1) == $past(exact_product(x_in, y_in), 1));
    a_r5_stage2_value: assert property (@(posedge clk) disable iff (rst)
        (fill >= 3'd2) |-> mat_value(r2) == $past(exact_product(x_in, y_in), 2));
    a_r5_stage3_value: assert property (@(posedge clk) disable iff (rst)
        (fill >= 3'd3) |-> mat_value(r3) == $past(exact_product(x_in, y_in), 3));
    // R6: generate/propagate register encodes the product
    a_r6_gp_value: assert property (@(posedge clk) disable iff (rst)
        (fill >= 3'd4) |-> gp_value(r4) == $past(exact_product(x_in, y_in), 4));
    // R1: six-edge latency on the output
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (fill >= 3'd6) |-> q == $past(exact_product(x_in, y_in), 6));
    // R2: output flushed to zero after reset and during refill
    a_r2_flush_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) || fill < 3'd6) |-> q == '0);

endmodule

// File: tb/dadda_mul_pipe_test.sv
module dadda_mul_pipe_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [31:0] q;

    int checks   = 0;
    int errors   = 0;
    int cyc      = 0;
    int post_rel = 0;

    typedef struct {
        logic [31:0] exp;
        int          due;
        string       tag;
        logic [15:0] xa;
        logic [15:0] ya;
    } item_t;

    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dadda_mul_pipe uut (.clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .q(q));

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa;
        logic signed [31:0] sb;
        sa = signed'({{16{a[15]}}, a});
        sb = signed'({{16{b[15]}}, b});
        return sa * sb;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: q=%h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Driver: apply one pair, queue its expected product, advance to next negedge.
    task automatic drive(input logic [15:0] a, input logic [15:0] b, input string tag);
        item_t it;
        x_in   = a;
        y_in   = b;
        it.exp = model(a, b);
        it.due = cyc + LAT;
        it.tag = tag;
        it.xa  = a;
        it.ya  = b;
        sbq.push_back(it);
        @(negedge clk);
        post_rel++;
        if (post_rel <= LAT - 1) check(q == 32'h0, "R2 refill", q, 32'h0);
    endtask

    task automatic mid_reset();
        rst  = 1'b1;
        x_in = 16'h5A5A;
        y_in = 16'hA5A5;
        sbq.delete();
        @(negedge clk);
        check(q == 32'h0, "R2 mid-stream reset", q, 32'h0);
        rst      = 1'b0;
        post_rel = 0;
    endtask

    // Monitor: compare each result when it is due.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (q !== it.exp) begin
                errors++;
                $display("FAIL %s: %h*%h q=%h expected %h", it.tag, it.xa, it.ya, q, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        x_in = 16'h7FFF;
        y_in = 16'h8000;
        repeat (3) @(negedge clk);
        check(q == 32'h0, "R2 reset state", q, 32'h0);
        rst      = 1'b0;
        post_rel = 0;

        // R1: distinct pairs back to back, each must land exactly LAT edges later
        drive(16'h00FF, 16'h0101, "R1");
        drive(16'h0003, 16'h0005, "R1");
        drive(16'h1234, 16'h0010, "R1");
        drive(16'h0000, 16'h7777, "R1");
        drive(16'h0101, 16'h0101, "R1");
        // R3: negative operands in either or both positions
        drive(16'hFFFD, 16'h0007, "R3");
        drive(16'h0064, 16'hFF06, "R3");
        drive(16'hCFC7, 16'h0002, "R3");
        drive(16'h7FFF, 16'hFFFF, "R3");
        drive(16'hFF9C, 16'hFE0C, "R3");
        // R4: most-negative operand
        drive(16'h8000, 16'h8000, "R4");
        drive(16'h8000, 16'h7FFF, "R4");
        drive(16'h8000, 16'h0001, "R4");
        drive(16'h8000, 16'hFFFF, "R4");
        drive(16'h0000, 16'h8000, "R4");
        // R6: long carry chains through the prefix adder
        drive(16'h7FFF, 16'h7FFF, "R6");
        drive(16'hFFFF, 16'h0001, "R6");
        drive(16'hFFFF, 16'hFFFF, "R6");
        drive(16'h00FF, 16'hFF01, "R6");
        drive(16'h0001, 16'h0000, "R6");
        // R7: unbroken random stream
        for (int i = 0; i < 150; i++) drive(16'($urandom), 16'($urandom), "R7");

        mid_reset();
        // R5: random stream after a reset, value carried through every stage
        for (int i = 0; i < 100; i++) drive(16'($urandom), 16'($urandom), "R5");
        for (int i = 0; i < LAT; i++) drive(16'h0000, 16'h0000, "R7");

        repeat (LAT + 1) @(negedge clk);
        check(sbq.size() == 0, "R7 all results drained", 32'(sbq.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule